// File: doc/BRIEF.md
# Thermal Overheat Interrupt Controller

This block watches 10-bit temperature codes that arrive from a few sensor channels, each with a valid strobe, and raises a level interrupt when the watched channel runs hot. Software sets up the block through a small register interface. A control word holds the trip threshold, a hysteresis code, the channel select and an interrupt enable. A cause register clears when read. A cause mask register and a top-level server mask gate the interrupt.

The hysteresis code sets a window half-width in codes. The event latches when a sample reaches the threshold plus the window. A read of the cause register releases the event only once the watched channel has reported a sample below the threshold minus the window. A read taken while the part is still warm therefore leaves the event pending, so no later event is lost. Only the channel named by the select field is compared. Moving the select moves the interrupt source, and the pending event stays set.

Top module: `thermal_ovh_irq`

## Requirements
- R1: After reset, `irq` is 0. The control word reads 0x000003FF (threshold at its maximum code 1023, all other fields 0). The cause, mask and server registers read 0.
- R2: The control word at 0x100 holds the threshold in bits [9:0], the hysteresis code in [13:12], the channel select in [17:16] and the interrupt enable in bit 24. The server mask at 0x104 keeps only bit 1, and the cause mask at 0x10C keeps only bit 22. All of these read back what was written to them.
- R3: The cause register at 0x108 sets bit 22 on a valid sample from the selected channel whose code is at least the high watermark. The high watermark is the threshold plus the window, saturated at 1023.
- R4: A sample whose valid strobe is low, or whose channel differs from the select field, never sets the cause.
- R5: `irq` is 1 one cycle after the cause bit, the cause mask bit, the server mask bit and the control enable are all 1. It is 0 one cycle after any of them is 0.
- R6: A read of 0x108 returns the cause and clears it only if the last selected-channel sample is below the low watermark. The low watermark is the threshold minus the window, floored at 0. Otherwise the event stays pending.
- R7: Hysteresis codes 0, 1, 2 and 3 give window half-widths of 4, 8, 16 and 32 codes.
- R8: Writing a new channel select does not clear a pending event. Only samples from the new channel count from then on, both for setting the event and for allowing a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | 2 | Channel of the sample |
| smp_code | input | 10 | Temperature code |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, 0 when not reading |
| irq | output | 1 | Registered overheat interrupt |

## Verification
On every cycle, the assertions check four things. The interrupt never rises without all four gating bits having been set one cycle earlier. The cause rises only on a valid selected-channel sample. Ignored samples cannot set it, and it falls only after a cause read. The bench scenarios cover what needs sequences over time: the exact watermark edges for each hysteresis code, saturation at both ends of the code range, a read that must leave a warm event pending, and the hand-over of the interrupt source after a change of channel select.

// File: rtl/thermal_ovh_irq.sv
module thermal_ovh_irq #(
  parameter int CODE_W     = 10,
  parameter int CHAN_W     = 2,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter logic [11:0] CTRL_ADDR  = 12'h100,
  parameter logic [11:0] SRV_ADDR   = 12'h104,
  parameter logic [11:0] CAUSE_ADDR = 12'h108,
  parameter logic [11:0] MASK_ADDR  = 12'h10C,
  parameter int OVH_BIT    = 22,
  parameter int SRV_BIT    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [CHAN_W-1:0] smp_chan,
  input  logic [CODE_W-1:0] smp_code,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int THR_LSB = 0;
  localparam int HYS_LSB = 12;
  localparam int SEL_LSB = 16;
  localparam int EN_BIT  = 24;
  localparam logic [CODE_W:0] CODE_MAX = {1'b0, {CODE_W{1'b1}}};

  logic [CODE_W-1:0] thr, cur_code;
  logic [1:0]        hys;
  logic [CHAN_W-1:0] sel;
  logic              en, cause, mask, srv, cur_ok;

  logic [CODE_W:0]   win, sum, high_w, low_w;
  logic              sel_hit, hit, below_low, rd_cause;
  logic              wr_ctrl, wr_srv, wr_mask;
  logic [CHAN_W-1:0] new_sel;

  assign win     = (CODE_W+1)'(4) << hys;
  assign sum     = {1'b0, thr} + win;
  assign high_w  = (sum > CODE_MAX) ? CODE_MAX : sum;
  assign low_w   = ({1'b0, thr} >= win) ? ({1'b0, thr} - win) : '0;

  assign sel_hit   = smp_valid && (smp_chan == sel);
  assign hit       = sel_hit && ({1'b0, smp_code} >= high_w);
  assign below_low = cur_ok && ({1'b0, cur_code} < low_w);
  assign rd_cause  = reg_rd && (reg_addr == ADDR_W'(CAUSE_ADDR));
  assign wr_ctrl   = reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR));
  assign wr_srv    = reg_wr && (reg_addr == ADDR_W'(SRV_ADDR));
  assign wr_mask   = reg_wr && (reg_addr == ADDR_W'(MASK_ADDR));
  assign new_sel   = reg_wdata[SEL_LSB +: CHAN_W];

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr <= '1;
      hys <= '0;
      sel <= '0;
      en  <= 1'b0;
    end else if (wr_ctrl) begin
      thr <= reg_wdata[THR_LSB +: CODE_W];
      hys <= reg_wdata[HYS_LSB +: 2];
      sel <= new_sel;
      en  <= reg_wdata[EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srv  <= 1'b0;
      mask <= 1'b0;
    end else begin
      if (wr_srv)  srv  <= reg_wdata[SRV_BIT];
      if (wr_mask) mask <= reg_wdata[OVH_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_code <= '0;
      cur_ok   <= 1'b0;
    end else if (wr_ctrl && (new_sel != sel)) begin
      cur_ok   <= 1'b0;
    end else if (sel_hit) begin
      cur_code <= smp_code;
      cur_ok   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cause <= 1'b0;
    else if (hit)                  cause <= 1'b1;
    else if (rd_cause && below_low) cause <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= cause && mask && srv && en;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        ADDR_W'(CTRL_ADDR): begin
          reg_rdata[THR_LSB +: CODE_W] = thr;
          reg_rdata[HYS_LSB +: 2]      = hys;
          reg_rdata[SEL_LSB +: CHAN_W] = sel;
          reg_rdata[EN_BIT]            = en;
        end
        ADDR_W'(SRV_ADDR):   reg_rdata[SRV_BIT] = srv;
        ADDR_W'(CAUSE_ADDR): reg_rdata[OVH_BIT] = cause;
        ADDR_W'(MASK_ADDR):  reg_rdata[OVH_BIT] = mask;
        default: reg_rdata = '0;
      endcase
    end
  end

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(cause && mask && srv && en));

  // R3
  cause_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause) |-> $past(smp_valid && (smp_chan == sel)));

  // R4
  ignored_smp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cause && !(smp_valid && (smp_chan == sel))) |=> !cause);

  // R6
  clear_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cause) |-> $past(reg_rd && (reg_addr == ADDR_W'(CAUSE_ADDR))));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause && !rd_cause) |=> cause);
endmodule

// File: tb/sim_thermal_ovh_irq.sv
module sim_thermal_ovh_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [1:0]  smp_chan = '0;
  logic [9:0]  smp_code = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        irq_probe = 1'b0;

  localparam logic [11:0] A_CTRL = 12'h100, A_SRV = 12'h104,
                          A_CAUSE = 12'h108, A_MASK = 12'h10C;
  localparam logic [31:0] CB = 32'h0040_0000;

  typedef struct { bit is_irq; logic [31:0] val; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  thermal_ovh_irq u0 (.clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_chan(smp_chan), .smp_code(smp_code), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #4 clk = ~clk;

  function automatic logic [31:0] ctrl(int thr, int hys, int sel, bit en);
    return (32'(en) << 24) | (32'(sel) << 16) | (32'(hys) << 12) | 32'(thr);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    tick(); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    item_t it;
    it.is_irq = 0; it.val = exp; it.tag = tag; q.push_back(it);
    tick(); reg_rd = 1'b1; reg_addr = a;
    tick(); reg_rd = 1'b0;
  endtask

  task automatic smp(bit v, int ch, int code);
    tick(); smp_valid = v; smp_chan = 2'(ch); smp_code = 10'(code);
    tick(); smp_valid = 1'b0;
  endtask

  task automatic chk_irq(bit exp, string tag);
    item_t it;
    it.is_irq = 1; it.val = 32'(exp); it.tag = tag; q.push_back(it);
    tick(); irq_probe = 1'b1;
    tick(); irq_probe = 1'b0;
  endtask

  always @(negedge clk) begin
    if (reg_rd || irq_probe) begin
      logic [31:0] act;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL monitor: result with empty queue, actual %h expected none", reg_rdata);
      end else begin
        item_t it;
        it = q.pop_front();
        act = it.is_irq ? 32'(irq) : reg_rdata;
        checks++;
        if (act !== it.val) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.val);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 50000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1'b1;
    // R1 reset state
    chk_irq(0, "R1 irq");
    rd(A_CTRL, 32'h3FF, "R1 ctrl");
    rd(A_CAUSE, 0, "R1 cause");
    rd(A_MASK, 0, "R1 mask");
    rd(A_SRV, 0, "R1 srv");
    // R2 layout
    wr(A_CTRL, ctrl(500, 0, 0, 1));
    rd(A_CTRL, ctrl(500, 0, 0, 1), "R2 ctrl");
    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_MASK, CB, "R2 mask");
    wr(A_SRV, 32'hFFFF_FFFF);
    rd(A_SRV, 32'h2, "R2 srv");
    // R3 / R4 threshold 500, window 4, high 504
    smp(1, 0, 503);  rd(A_CAUSE, 0, "R3 below high");
    smp(1, 1, 900);  rd(A_CAUSE, 0, "R4 other channel");
    smp(0, 0, 1000); rd(A_CAUSE, 0, "R4 no strobe");
    smp(1, 0, 504);  chk_irq(1, "R5 irq up");
    rd(A_CAUSE, CB, "R3 at high");
    rd(A_CAUSE, CB, "R6 warm read keeps");
    // R6 low 496
    smp(1, 0, 496); rd(A_CAUSE, CB, "R6 at low"); rd(A_CAUSE, CB, "R6 at low kept");
    smp(1, 0, 495); rd(A_CAUSE, CB, "R6 read returns"); rd(A_CAUSE, 0, "R6 cleared");
    tick(); chk_irq(0, "R5 irq down after clear");
    // R5 gating
    smp(1, 0, 600); chk_irq(1, "R5 all set");
    wr(A_SRV, 0); tick(); chk_irq(0, "R5 server off");
    wr(A_SRV, 2); tick(); chk_irq(1, "R5 server on");
    wr(A_MASK, 0); tick(); chk_irq(0, "R5 mask off");
    wr(A_MASK, CB); tick(); chk_irq(1, "R5 mask on");
    wr(A_CTRL, ctrl(500, 0, 0, 0)); tick(); chk_irq(0, "R5 enable off");
    smp(1, 0, 0); rd(A_CAUSE, CB, "R6 cleanup"); rd(A_CAUSE, 0, "R6 cleanup done");
    // R7 window 32: high 532, low 468
    wr(A_CTRL, ctrl(500, 3, 0, 1));
    smp(1, 0, 531); rd(A_CAUSE, 0, "R7 w32 below");
    smp(1, 0, 532); rd(A_CAUSE, CB, "R7 w32 hit");
    smp(1, 0, 468); rd(A_CAUSE, CB, "R7 w32 low edge"); rd(A_CAUSE, CB, "R7 w32 kept");
    smp(1, 0, 467); rd(A_CAUSE, CB, "R7 w32 ret"); rd(A_CAUSE, 0, "R7 w32 cleared");
    // R7 window 8: high 508, low 492
    wr(A_CTRL, ctrl(500, 1, 0, 1));
    smp(1, 0, 507); rd(A_CAUSE, 0, "R7 w8 below");
    smp(1, 0, 508); rd(A_CAUSE, CB, "R7 w8 hit");
    smp(1, 0, 492); rd(A_CAUSE, CB, "R7 w8 low"); rd(A_CAUSE, CB, "R7 w8 kept");
    smp(1, 0, 491); rd(A_CAUSE, CB, "R7 w8 ret"); rd(A_CAUSE, 0, "R7 w8 cleared");
    // R7 window 16: high 516
    wr(A_CTRL, ctrl(500, 2, 0, 1));
    smp(1, 0, 515); rd(A_CAUSE, 0, "R7 w16 below");
    smp(1, 0, 516); rd(A_CAUSE, CB, "R7 w16 hit");
    smp(1, 0, 483); rd(A_CAUSE, CB, "R7 w16 ret"); rd(A_CAUSE, 0, "R7 w16 cleared");
    // R3 saturation at top
    wr(A_CTRL, ctrl(1020, 3, 0, 1));
    smp(1, 0, 1022); rd(A_CAUSE, 0, "R3 sat below");
    smp(1, 0, 1023); rd(A_CAUSE, CB, "R3 sat hit");
    // R6 floor at 0: no clear possible
    wr(A_CTRL, ctrl(10, 3, 0, 1));
    smp(1, 0, 0); rd(A_CAUSE, CB, "R6 floor ret"); rd(A_CAUSE, CB, "R6 floor kept");
    wr(A_CTRL, ctrl(100, 3, 0, 1));
    smp(1, 0, 0); rd(A_CAUSE, CB, "R6 ret"); rd(A_CAUSE, 0, "R6 cleared thr100");
    // R8 channel switching
    wr(A_CTRL, ctrl(500, 0, 2, 1));
    smp(1, 0, 900); rd(A_CAUSE, 0, "R8 ch0 ignored");
    smp(1, 2, 600); rd(A_CAUSE, CB, "R8 ch2 hit");
    wr(A_CTRL, ctrl(500, 0, 1, 1));
    rd(A_CAUSE, CB, "R8 pending kept"); rd(A_CAUSE, CB, "R8 no new sample");
    smp(1, 2, 0); rd(A_CAUSE, CB, "R8 old ch ignored"); rd(A_CAUSE, CB, "R8 old ch kept");
    smp(1, 1, 0); rd(A_CAUSE, CB, "R8 new ch ret"); rd(A_CAUSE, 0, "R8 new ch cleared");
    smp(1, 2, 900); rd(A_CAUSE, 0, "R8 old ch no set");
    smp(1, 1, 504); rd(A_CAUSE, CB, "R8 new ch set");
    repeat (3) tick();
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d left expected 0", q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule